// File: doc/BRIEF.md
# Ratio-Balancing Priority Transaction Scheduler

This block picks the next transaction to send over one master-to-slave link. Transactions wait in a small queue, and each one carries a type (read or write), a priority and a tag. Whenever the link is free, the scheduler removes one entry and announces it with a single-cycle grant pulse. The link then raises its busy input until the transfer has finished. A grant is never withdrawn or replaced, so a transfer that has started always completes, even if a higher-priority entry arrives while it runs.

The scheduler keeps two counters: one for the reads it has issued and one for the writes. Each transaction adds one to a counter, whatever its size. An 8-bit ratio input gives the target share of reads as a fraction of 256. When the ratio is nonzero, the scheduler first chooses the type that is falling behind the target, then takes the best entry of that type. A ratio of zero turns balancing off, and the scheduler then picks purely by priority. The ratio may change at any time, and the next decision uses the new value. Both counters are visible on output ports.

Top module: `rw_ratio_sched`

## Requirements
- R1: After reset the queue is empty, `grant_valid` is 0, both counters are 0 and `enq_ready` is 1.
- R2: The queue holds DEPTH entries. `enq_ready` is 0 while the queue is full, and an enqueue attempted then is dropped: its tag is never granted.
- R3: A grant is issued only on a clock edge where `link_busy` is 0 and the queue is not empty. It lasts one cycle, is followed by at least one cycle without a grant, and removes its entry from the queue.
- R4: With `ratio` equal to 0, the entry with the highest priority wins, regardless of type. A larger `enq_prio` value means a higher priority.
- R5: Among entries of the same type and the same priority, the one enqueued first wins.
- R6: With `ratio` nonzero and both types pending, reads are chosen when rd_count*256 <= ratio*(rd_count+wr_count), and writes are chosen otherwise. Every grant counts as one transaction.
- R7: When only one type is pending, an entry of that type is granted whatever the ratio says.
- R8: An entry that arrives while `link_busy` is 1 gets no grant until `link_busy` returns to 0, whatever its priority.
- R9: `rd_count` increases by one on each read grant and `wr_count` by one on each write grant, in the same cycle the grant appears. A change to `ratio` takes effect at the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_is_write | input | 1 | Type of the new entry: 1 for write, 0 for read |
| enq_prio | input | PRIO_W | Priority of the new entry; a larger value means a higher priority |
| enq_tag | input | TAG_W | Identifier of the new entry |
| enq_ready | output | 1 | Queue has room for another entry |
| link_busy | input | 1 | The link is still carrying the previous transfer |
| ratio | input | 8 | Target read share in units of 1/256; 0 turns balancing off |
| grant_valid | output | 1 | One-cycle pulse announcing the chosen entry |
| grant_is_write | output | 1 | Type of the granted entry |
| grant_tag | output | TAG_W | Tag of the granted entry |
| rd_count | output | CNT_W | Reads issued since reset |
| wr_count | output | CNT_W | Writes issued since reset |

## Verification
The assertions assume that `link_busy` follows the link's real state. They also assume that nothing outside the block refills the queue through any path other than the enqueue port, so the occupancy bound and the no-change-when-full rule depend on the handshake alone. The stimulus strobes `enq_valid` for exactly one cycle per entry, changes inputs only at falling edges, and keeps the counters far below wrap-around. Each ratio scenario begins from a fresh reset, so the expected grant order can be derived from zero counts.

// File: rtl/rw_ratio_sched.sv
module rw_ratio_sched #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 3,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic              enq_is_write,
  input  logic [PRIO_W-1:0] enq_prio,
  input  logic [TAG_W-1:0]  enq_tag,
  output logic              enq_ready,
  input  logic              link_busy,
  input  logic [7:0]        ratio,
  output logic              grant_valid,
  output logic              grant_is_write,
  output logic [TAG_W-1:0]  grant_tag,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int MUL_W = CNT_W + 9;

  logic [DEPTH-1:0]  q_wr, n_wr;
  logic [PRIO_W-1:0] q_pr [DEPTH];
  logic [PRIO_W-1:0] n_pr [DEPTH];
  logic [TAG_W-1:0]  q_tg [DEPTH];
  logic [TAG_W-1:0]  n_tg [DEPTH];
  logic [OCC_W-1:0]  occ, n_occ, occ_a;

  logic              rd_hit, wr_hit;
  logic [IDX_W-1:0]  rd_idx, wr_idx, sel_idx;
  logic [PRIO_W-1:0] rd_p, wr_p;
  logic              pick_wr, read_lags, issue, push;
  logic [MUL_W-1:0]  lhs, rhs;

  assign enq_ready = (occ != OCC_W'(DEPTH));
  assign push      = enq_valid && enq_ready;
  assign issue     = !link_busy && !grant_valid && (occ != '0);

  always_comb begin
    rd_hit = 1'b0; wr_hit = 1'b0;
    rd_idx = '0;   wr_idx = '0;
    rd_p   = '0;   wr_p   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(occ)) begin
        if (q_wr[i]) begin
          if (!wr_hit || q_pr[i] > wr_p) begin
            wr_hit = 1'b1; wr_p = q_pr[i]; wr_idx = i[IDX_W-1:0];
          end
        end else begin
          if (!rd_hit || q_pr[i] > rd_p) begin
            rd_hit = 1'b1; rd_p = q_pr[i]; rd_idx = i[IDX_W-1:0];
          end
        end
      end
    end
  end

  assign lhs       = {1'b0, rd_count, 8'b0};
  assign rhs       = MUL_W'(ratio) * (MUL_W'(rd_count) + MUL_W'(wr_count));
  assign read_lags = (lhs <= rhs);

  always_comb begin
    if (!rd_hit)          pick_wr = 1'b1;
    else if (!wr_hit)     pick_wr = 1'b0;
    else if (ratio == 0)  pick_wr = (wr_p > rd_p) || (wr_p == rd_p && wr_idx < rd_idx);
    else                  pick_wr = !read_lags;
  end
  assign sel_idx = pick_wr ? wr_idx : rd_idx;

  always_comb begin
    n_wr = q_wr;
    for (int i = 0; i < DEPTH; i++) begin
      n_pr[i] = q_pr[i];
      n_tg[i] = q_tg[i];
    end
    if (issue) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel_idx)) begin
          n_wr[i] = q_wr[i+1];
          n_pr[i] = q_pr[i+1];
          n_tg[i] = q_tg[i+1];
        end
      end
    end
    occ_a = occ - OCC_W'(issue);
    if (push) begin
      n_wr[occ_a[IDX_W-1:0]] = enq_is_write;
      n_pr[occ_a[IDX_W-1:0]] = enq_prio;
      n_tg[occ_a[IDX_W-1:0]] = enq_tag;
    end
    n_occ = occ_a + OCC_W'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      q_wr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_pr[i] <= '0;
        q_tg[i] <= '0;
      end
      grant_valid <= 1'b0;
      grant_is_write <= 1'b0;
      grant_tag <= '0;
      rd_count <= '0;
      wr_count <= '0;
    end else begin
      occ <= n_occ;
      q_wr <= n_wr;
      for (int i = 0; i < DEPTH; i++) begin
        q_pr[i] <= n_pr[i];
        q_tg[i] <= n_tg[i];
      end
      grant_valid <= issue;
      if (issue) begin
        grant_is_write <= pick_wr;
        grant_tag <= q_tg[sel_idx];
        if (pick_wr) wr_count <= wr_count + 1'b1;
        else         rd_count <= rd_count + 1'b1;
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready && !issue) |=> (occ == $past(occ)));

  // R3
  grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_busy |=> !grant_valid);

  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> ($stable(rd_count) && $stable(wr_count)));

  // R9
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_is_write) |-> (rd_count == $past(rd_count) + 1'b1));

endmodule

// File: tb/tb_rw_ratio_sched.sv
module tb_rw_ratio_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic       enq_is_write = 1'b0;
  logic [2:0] enq_prio = '0;
  logic [3:0] enq_tag = '0;
  logic       enq_ready;
  logic       link_busy = 1'b0;
  logic [7:0] ratio = '0;
  logic       grant_valid, grant_is_write;
  logic [3:0] grant_tag;
  logic [15:0] rd_count, wr_count;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rw_ratio_sched dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_is_write(enq_is_write),
    .enq_prio(enq_prio), .enq_tag(enq_tag), .enq_ready(enq_ready),
    .link_busy(link_busy), .ratio(ratio), .grant_valid(grant_valid),
    .grant_is_write(grant_is_write), .grant_tag(grant_tag),
    .rd_count(rd_count), .wr_count(wr_count)
  );

  // entry = {is_write, prio[2:0], tag[3:0]}; vector = {ratio, e0..e3, expected tags t0..t3}
  typedef logic [55:0] vec_t;
  localparam vec_t VECS [6] = '{
    {8'd0,   8'h11, 8'h32, 8'h33, 8'h24, 16'h2341}, // R4 R5 reads only by priority
    {8'd0,   8'h21, 8'hD2, 8'h53, 8'h84, 16'h2314}, // R4 mixed types
    {8'd128, 8'h01, 8'h72, 8'h93, 8'hE4, 16'h2413}, // R6 50 percent
    {8'd64,  8'h31, 8'h32, 8'h83, 8'hA4, 16'h1432}, // R6 R7 25 percent
    {8'd255, 8'hF1, 8'h92, 8'h03, 8'h04, 16'h3142}, // R6 near all reads
    {8'd200, 8'hA1, 8'hA2, 8'hC3, 8'h94, 16'h3124}  // R7 R5 writes only
  };

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; link_busy = 1'b0; enq_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enq(input logic [7:0] e);
    enq_valid = 1'b1;
    enq_is_write = e[7];
    enq_prio = e[6:4];
    enq_tag = e[3:0];
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wait_grant(output int tag, output int iswr);
    tag = -1; iswr = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (grant_valid) begin
        tag = grant_tag; iswr = grant_is_write;
        break;
      end
    end
  endtask

  initial begin
    int tag, iswr, seen;
    do_reset();
    // R1 reset state
    check("R1 grant_valid", grant_valid, 0);
    check("R1 rd_count", rd_count, 0);
    check("R1 wr_count", wr_count, 0);
    check("R1 enq_ready", enq_ready, 1);

    foreach (VECS[v]) begin
      do_reset();
      link_busy = 1'b1;
      ratio = VECS[v][55:48];
      for (int j = 0; j < 4; j++) enq(VECS[v][47 - 8*j -: 8]);
      link_busy = 1'b0;
      for (int j = 0; j < 4; j++) begin
        wait_grant(tag, iswr);
        check($sformatf("R4 R5 R6 R7 vector %0d grant %0d", v, j), tag, int'(VECS[v][15 - 4*j -: 4]));
      end
      if (v == 2) begin
        check("R9 rd_count after balanced run", rd_count, 2);
        check("R9 wr_count after balanced run", wr_count, 2);
      end
    end

    // R2 full queue drops the fifth entry
    do_reset();
    link_busy = 1'b1;
    for (int j = 1; j <= 4; j++) enq({1'b0, 3'd1, 4'(j)});
    check("R2 enq_ready when full", enq_ready, 0);
    enq({1'b1, 3'd7, 4'd9});
    link_busy = 1'b0;
    seen = 0;
    for (int j = 0; j < 4; j++) begin
      wait_grant(tag, iswr);
      if (tag == 9) seen = 1;
      check("R3 grant type read", iswr, 0);
    end
    wait_grant(tag, iswr);
    check("R2 dropped entry never granted", (seen == 1 || tag != -1) ? 1 : 0, 0);

    // R8 no preemption while link busy
    do_reset();
    enq({1'b0, 3'd0, 4'd1});
    wait_grant(tag, iswr);
    check("R8 first grant", tag, 1);
    link_busy = 1'b1;
    enq({1'b1, 3'd7, 4'd2});
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (grant_valid) seen = 1;
    end
    check("R8 no grant while busy", seen, 0);
    check("R3 enq_ready with one pending", enq_ready, 1);
    link_busy = 1'b0;
    wait_grant(tag, iswr);
    check("R8 grant after busy drops", tag, 2);
    check("R9 wr_count", wr_count, 1);
    check("R9 rd_count", rd_count, 1);

    // R9 ratio rewritten between decisions
    do_reset();
    link_busy = 1'b1;
    ratio = 8'd0;
    enq({1'b0, 3'd7, 4'd1});
    enq({1'b0, 3'd0, 4'd3});
    enq({1'b1, 3'd0, 4'd2});
    link_busy = 1'b0;
    wait_grant(tag, iswr);
    check("R9 first grant under ratio 0", tag, 1);
    ratio = 8'd128;
    wait_grant(tag, iswr);
    check("R9 new ratio steers to write", tag, 2);
    check("R9 grant type write", iswr, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule